// File: doc/BRIEF.md
# Dual-Rate Audio Serial Port

This block is a slave-side serial audio port. It moves stereo samples across one shared bit clock in both directions at once. Playback samples arrive on the serial data input, framed by a playback word clock, and are handed to the core as a left/right pair. Record samples from the core leave on the serial data output, framed by a second, independent record word clock. Because the two directions share only the bit clock, they can run at different frame rates. Tying both word clocks to the same source gives an ordinary single-rate interface.

Two framing styles are supported. In pulse framing, a one-bit-clock-wide high pulse on a word clock opens a frame, and the left and right words follow back to back. In level framing, a word clock held high marks the left half-frame and held low marks the right half-frame. A programmable offset, counted in bit clocks, pushes each word's first bit later relative to its marker. The word length is selectable as 16, 20, 24 or 32 bits.

All serial pins are sampled by the core clock, which must run at least six times faster than the bit clock. Bit-clock edges are found by comparing successive samples.

Top module: `duo_rate_audio_port`

## Requirements
- R1: While `rst` is high at a core clock edge, `dout`, `rx_valid`, `rx_left` and `rx_right` are all driven to zero.
- R2: Words travel most significant bit first, from bit N-1 down to bit 0. On the core side each sample is MSB-aligned in a SAMPLE_W-bit port, occupying bits [SAMPLE_W-1 : SAMPLE_W-N]. Received samples carry zeros below that field, and the lower transmit bits are never sent.
- R3: With `fmt_sel`=0 (pulse framing), a frame marker is a bit-clock rising edge at which the word clock is seen high after being low. Left bit k is taken at the rising edge 1+offset+k edges after the marker, and the right word follows immediately after it.
- R4: With `fmt_sel`=1 (level framing), a rising edge seen on the word clock opens the left half and a falling edge opens the right half. Within each half, bit k is taken at the rising edge 1+offset+k edges after the half opens.
- R5: After the last right-channel bit is taken from `din`, `rx_left` and `rx_right` update together and `rx_valid` is high for exactly one core clock. Values on `din` outside the data slots have no effect.
- R6: `dout` changes only after a bit-clock falling edge. It carries the bit belonging to the next rising edge, and it is zero in every slot that holds no data bit.
- R7: `tx_left` and `tx_right` are captured at each record frame start (the `adwk` marker in pulse framing, an `adwk` rise in level framing). Later changes to them do not alter the frame in progress.
- R8: Playback frames are located only by `wclk` and record frames only by `adwk`. Both use `bclk`, and the two frame lengths may differ. Driving both word clocks from one source gives single-rate operation.
- R9: `wlen_sel` selects the word length N: 0 gives 16, 1 gives 20, 2 gives 24, 3 gives 32.
- R10: `word_ofs` sets the offset, from 0 to 2^OFS_W-1 bit clocks. The offset applies in both framing styles.
- R11: Until a direction has seen its first marker after reset, it is idle: `dout` stays zero and no `rx_valid` strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; samples all serial pins |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 1 | Framing style: 0 pulse, 1 level |
| wlen_sel | input | 2 | Word length code |
| word_ofs | input | OFS_W | Data word offset in bit clocks |
| bclk | input | 1 | Shared serial bit clock |
| wclk | input | 1 | Playback word clock |
| adwk | input | 1 | Record word clock |
| din | input | 1 | Serial playback data |
| dout | output | 1 | Serial record data |
| tx_left | input | SAMPLE_W | Record sample, left channel |
| tx_right | input | SAMPLE_W | Record sample, right channel |
| rx_left | output | SAMPLE_W | Received playback sample, left channel |
| rx_right | output | SAMPLE_W | Received playback sample, right channel |
| rx_valid | output | 1 | One-cycle strobe when a received pair updates |

## Verification
The bench builds the port with SAMPLE_W=32 and OFS_W=8. At those values every word-length code can be reached, including the full 32-bit word that fills the sample port. It sweeps both framing styles, all four word lengths and offsets 0 and 7. Three frame-length pairings are used: identical word clocks, a record frame twice as long as the playback frame, and a record frame shorter than the playback frame. Every serial output bit and every received pair is compared against values the bench derives arithmetically from slot positions.

// File: rtl/duo_port_pkg.sv
package duo_port_pkg;

    localparam int POS_W = 8;

    typedef enum logic {
        FRAME_PULSE = 1'b0,
        FRAME_LEVEL = 1'b1
    } frame_fmt_e;

    typedef enum logic [1:0] {
        WORD_16 = 2'd0,
        WORD_20 = 2'd1,
        WORD_24 = 2'd2,
        WORD_32 = 2'd3
    } word_len_e;

    typedef struct packed {
        logic             active;
        logic             right;
        logic [POS_W-1:0] pos;
    } slot_info_t;

    // R9: word length code to bit count
    function automatic int unsigned word_bits(word_len_e wl);
        case (wl)
            WORD_16: return 16;
            WORD_20: return 20;
            WORD_24: return 24;
            default: return 32;
        endcase
    endfunction

    // Map a slot count (bit clocks since marker) to channel and bit position.
    function automatic slot_info_t decode_slot(frame_fmt_e fmt, logic half,
                                               int unsigned cnt, int unsigned ofs,
                                               int unsigned nbits);
        slot_info_t  s;
        int unsigned p;
        s = '0;
        p = 0;
        if (cnt >= ofs) begin
            p = cnt - ofs;
            if (fmt == FRAME_PULSE) begin
                if (p < nbits) begin
                    s.active = 1'b1;
                    s.pos    = POS_W'(p);
                end else if (p < 2 * nbits) begin
                    s.active = 1'b1;
                    s.right  = 1'b1;
                    s.pos    = POS_W'(p - nbits);
                end
            end else if (p < nbits) begin
                s.active = 1'b1;
                s.right  = half;
                s.pos    = POS_W'(p);
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/duo_edge_sync.sv
module duo_edge_sync #(
    parameter int LINES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bclk,
    input  logic [LINES-1:0] lines_in,
    output logic             rise,
    output logic             fall,
    output logic [LINES-1:0] lines_s
);
    logic bclk_s;
    logic bclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_s  <= 1'b0;
            bclk_d  <= 1'b0;
            lines_s <= '0;
        end else begin
            bclk_s  <= bclk;
            bclk_d  <= bclk_s;
            lines_s <= lines_in;
        end
    end

    assign rise = bclk_s & ~bclk_d;
    assign fall = ~bclk_s & bclk_d;

endmodule

// File: rtl/duo_slot_tracker.sv
module duo_slot_tracker
    import duo_port_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             wc,
    input  frame_fmt_e       fmt,
    output logic [CNT_W-1:0] cnt,
    output logic             half,
    output logic             frame_start
);
    logic wc_d;
    logic edge_up;
    logic edge_dn;
    logic half_start;

    assign edge_up     = rise & wc & ~wc_d;
    assign edge_dn     = rise & ~wc & wc_d;
    assign half_start  = edge_up | ((fmt == FRAME_LEVEL) & edge_dn);
    assign frame_start = edge_up;

    // cnt holds the slot index of the next rising edge; all-ones means idle
    always_ff @(posedge clk) begin
        if (rst) begin
            wc_d <= 1'b0;
            cnt  <= '1;
            half <= 1'b0;
        end else if (rise) begin
            wc_d <= wc;
            if (half_start) begin
                cnt  <= '0;
                half <= (fmt == FRAME_LEVEL) & edge_dn;
            end else if (cnt != '1) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    a_r4_half_restart: assert property (@(posedge clk) disable iff (rst)
        half_start |=> (cnt == '0));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(cnt) && $stable(half));

endmodule

// File: rtl/duo_rx_deser.sv
module duo_rx_deser
    import duo_port_pkg::*;
#(
    parameter int SAMPLE_W = 32,
    parameter int CNT_W    = 9,
    parameter int OFS_W    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rise,
    input  logic                din,
    input  frame_fmt_e          fmt,
    input  word_len_e           wlen,
    input  logic [OFS_W-1:0]    ofs,
    input  logic [CNT_W-1:0]    cnt,
    input  logic                half,
    input  logic                frame_start,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                rx_valid
);
    localparam int IDX_W = $clog2(SAMPLE_W);

    slot_info_t          slot;
    int unsigned         nb;
    logic [IDX_W-1:0]    idx;
    logic [SAMPLE_W-1:0] acc;
    logic [SAMPLE_W-1:0] acc_nx;
    logic [SAMPLE_W-1:0] left_hold;
    logic                take;
    logic                done;

    always_comb begin
        nb     = word_bits(wlen);
        slot   = decode_slot(fmt, half, 32'(cnt), 32'(ofs), nb);
        idx    = IDX_W'(SAMPLE_W - 1 - int'(slot.pos));
        acc_nx = (slot.pos == '0) ? '0 : acc;
        acc_nx[idx] = din;
        take   = rise & slot.active;
        done   = take & (slot.pos == POS_W'(nb - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            left_hold <= '0;
            rx_left   <= '0;
            rx_right  <= '0;
            rx_valid  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (take) begin
                acc <= acc_nx;
            end
            if (done && !slot.right) begin
                left_hold <= acc_nx;
            end else if (frame_start) begin
                left_hold <= '0;
            end
            if (done && slot.right) begin
                rx_left  <= left_hold;
                rx_right <= acc_nx;
                rx_valid <= 1'b1;
            end
        end
    end

    a_r5_one_cycle_strobe: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    a_r5_pair_on_edge: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(rx_left) && $stable(rx_right));

endmodule

// File: rtl/duo_tx_ser.sv
module duo_tx_ser
    import duo_port_pkg::*;
#(
    parameter int SAMPLE_W = 32,
    parameter int CNT_W    = 9,
    parameter int OFS_W    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fall,
    input  logic                frame_start,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    input  frame_fmt_e          fmt,
    input  word_len_e           wlen,
    input  logic [OFS_W-1:0]    ofs,
    input  logic [CNT_W-1:0]    cnt,
    input  logic                half,
    output logic                dout
);
    localparam int IDX_W = $clog2(SAMPLE_W);

    slot_info_t          slot;
    logic [IDX_W-1:0]    idx;
    logic [SAMPLE_W-1:0] sh_l;
    logic [SAMPLE_W-1:0] sh_r;
    logic                bit_nx;

    always_comb begin
        slot   = decode_slot(fmt, half, 32'(cnt), 32'(ofs), word_bits(wlen));
        idx    = IDX_W'(SAMPLE_W - 1 - int'(slot.pos));
        bit_nx = slot.active & (slot.right ? sh_r[idx] : sh_l[idx]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_l <= '0;
            sh_r <= '0;
            dout <= 1'b0;
        end else begin
            if (frame_start) begin
                sh_l <= tx_left;
                sh_r <= tx_right;
            end
            if (fall) begin
                dout <= bit_nx;
            end
        end
    end

    a_r6_change_after_fall: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(dout));

    a_r11_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        (fall && (cnt == '1)) |=> (dout == 1'b0));

    a_r7_latch_window: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(sh_l) && $stable(sh_r));

endmodule

// File: rtl/duo_rate_audio_port.sv
module duo_rate_audio_port
    import duo_port_pkg::*;
#(
    parameter int SAMPLE_W = 32,
    parameter int OFS_W    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fmt_sel,
    input  logic [1:0]          wlen_sel,
    input  logic [OFS_W-1:0]    word_ofs,
    input  logic                bclk,
    input  logic                wclk,
    input  logic                adwk,
    input  logic                din,
    output logic                dout,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                rx_valid
);
    // counter must pass the last data slot before reaching its idle value
    localparam int CNT_W   = $clog2((1 << OFS_W) + 2 * SAMPLE_W + 1);
    localparam int N_DIR   = 2;
    localparam int DIR_PLY = 0;
    localparam int DIR_REC = 1;

    frame_fmt_e       fmt_q;
    word_len_e        wlen_q;
    logic             rise;
    logic             fall;
    logic [2:0]       pins_s;
    logic [N_DIR-1:0] wc_s;
    logic [CNT_W-1:0] trk_cnt   [N_DIR];
    logic             trk_half  [N_DIR];
    logic             trk_start [N_DIR];

    assign fmt_q  = frame_fmt_e'(fmt_sel);
    assign wlen_q = word_len_e'(wlen_sel);

    duo_edge_sync #(.LINES(3)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .bclk     (bclk),
        .lines_in ({din, adwk, wclk}),
        .rise     (rise),
        .fall     (fall),
        .lines_s  (pins_s)
    );

    assign wc_s = pins_s[1:0];

    for (genvar g = 0; g < N_DIR; g++) begin : g_trk
        duo_slot_tracker #(.CNT_W(CNT_W)) u_trk (
            .clk         (clk),
            .rst         (rst),
            .rise        (rise),
            .wc          (wc_s[g]),
            .fmt         (fmt_q),
            .cnt         (trk_cnt[g]),
            .half        (trk_half[g]),
            .frame_start (trk_start[g])
        );
    end

    duo_rx_deser #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W), .OFS_W(OFS_W)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .rise        (rise),
        .din         (pins_s[2]),
        .fmt         (fmt_q),
        .wlen        (wlen_q),
        .ofs         (word_ofs),
        .cnt         (trk_cnt[DIR_PLY]),
        .half        (trk_half[DIR_PLY]),
        .frame_start (trk_start[DIR_PLY]),
        .rx_left     (rx_left),
        .rx_right    (rx_right),
        .rx_valid    (rx_valid)
    );

    duo_tx_ser #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W), .OFS_W(OFS_W)) u_tx (
        .clk         (clk),
        .rst         (rst),
        .fall        (fall),
        .frame_start (trk_start[DIR_REC]),
        .tx_left     (tx_left),
        .tx_right    (tx_right),
        .fmt         (fmt_q),
        .wlen        (wlen_q),
        .ofs         (word_ofs),
        .cnt         (trk_cnt[DIR_REC]),
        .half        (trk_half[DIR_REC]),
        .dout        (dout)
    );

    // R1: reset clears the serial output and the received pair
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (dout == 1'b0) && (rx_valid == 1'b0) && (rx_left == '0) && (rx_right == '0));

endmodule

// File: tb/test_duo_rate_audio_port.sv
module test_duo_rate_audio_port;
    localparam int SW = 32;
    localparam int OW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fmt_sel = 1'b0;
    logic [1:0]    wlen_sel = 2'd0;
    logic [OW-1:0] word_ofs = '0;
    logic          bclk = 1'b0;
    logic          wclk = 1'b0;
    logic          adwk = 1'b0;
    logic          din = 1'b0;
    logic          dout;
    logic [SW-1:0] tx_left = '0;
    logic [SW-1:0] tx_right = '0;
    logic [SW-1:0] rx_left;
    logic [SW-1:0] rx_right;
    logic          rx_valid;

    int checks = 0;
    int errors = 0;
    int cfg_id = 0;
    int cfg_fmt = 0;
    int cfg_n = 16;
    int cfg_ofs = 0;
    int fl_w = 32;
    int fl_a = 32;
    int rx_seen = 0;
    logic [SW-1:0] cfg_mask = '1;
    bit finished = 0;

    always #10 clk = ~clk;

    duo_rate_audio_port #(.SAMPLE_W(SW), .OFS_W(OW)) i_duo_rate_audio_port (
        .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .wlen_sel(wlen_sel), .word_ofs(word_ofs),
        .bclk(bclk), .wclk(wclk), .adwk(adwk), .din(din), .dout(dout),
        .tx_left(tx_left), .tx_right(tx_right),
        .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
    );

    function automatic logic [31:0] pat(int tag, int idx);
        logic [31:0] a;
        logic [31:0] b;
        a = 32'(tag);
        b = 32'(idx + 1);
        return (a * 32'h9E3779B9) ^ (b * 32'h85EBCA6B) ^ 32'h3C96A51E;
    endfunction

    // {active, bit} for the slot taken at rising edge e of a stream with frame length fl
    function automatic logic [1:0] slot_bit(int e, int fl, int tag);
        int h;
        int frm;
        int ch;
        int p;
        logic [31:0] w;
        if (e == 0) return 2'b00;
        if (cfg_fmt == 0) begin
            frm = (e - 1) / fl;
            p   = (e - 1) % fl - cfg_ofs;
            if (p < 0 || p >= 2 * cfg_n) return 2'b00;
            ch = (p >= cfg_n) ? 1 : 0;
            if (ch == 1) p = p - cfg_n;
        end else begin
            h   = fl / 2;
            frm = ((e - 1) / h) / 2;
            ch  = ((e - 1) / h) % 2;
            p   = (e - 1) % h - cfg_ofs;
            if (p < 0 || p >= cfg_n) return 2'b00;
        end
        w = pat(tag + ch, frm);
        return {1'b1, w[31 - p]};
    endfunction

    function automatic logic wc_level(int e, int fl);
        if (cfg_fmt == 0) return (e % fl) == 0;
        return (e % fl) < (fl / 2);
    endfunction

    // R5/R2: every received pair against the playback words, MSB-aligned, zero below N
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            logic [SW-1:0] el;
            logic [SW-1:0] er;
            el = pat(4 * cfg_id, rx_seen) & cfg_mask;
            er = pat(4 * cfg_id + 1, rx_seen) & cfg_mask;
            checks++;
            if (rx_left !== el || rx_right !== er) begin
                errors++;
                $display("FAIL R5 cfg %0d pair %0d: got %h/%h expected %h/%h",
                         cfg_id, rx_seen, rx_left, rx_right, el, er);
            end
            rx_seen++;
        end
    end

    task automatic check_dout(logic exp, string tag, int e);
        checks++;
        if (dout !== exp) begin
            errors++;
            $display("FAIL %s cfg %0d edge %0d: dout %b expected %b", tag, cfg_id, e, dout, exp);
        end
    endtask

    // one bit-clock period: low half (drive, check dout), then high half
    task automatic step(int e, bit idle);
        logic [1:0] r;
        logic [1:0] t;
        int g;
        @(negedge clk);
        bclk = 1'b0;
        if (idle) begin
            wclk = 1'b0;
            adwk = 1'b0;
            din  = 1'b1;
            t    = 2'b00;
        end else begin
            wclk = wc_level(e, fl_w);          // R8: playback framed by wclk
            adwk = wc_level(e, fl_a);          // R8: record framed by adwk
            r    = slot_bit(e, fl_w, 4 * cfg_id);
            din  = r[1] ? r[0] : (e % 3 == 1); // R5: junk outside data slots
            g    = (e + fl_a - 1) / fl_a;      // R7: next frame's words appear mid-frame
            tx_left  = pat(4 * cfg_id + 2, g);
            tx_right = pat(4 * cfg_id + 3, g);
            t = slot_bit(e, fl_a, 4 * cfg_id + 2);
        end
        repeat (3) @(negedge clk);
        // R6/R7/R2, with R3 or R4 framing on the record side
        check_dout(t[1] & t[0], idle ? "R11" : (cfg_fmt == 0 ? "R6 R3" : "R6 R4"), e);
        bclk = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_cfg(int f, int wl, int o, int variant);
        int base;
        int edges;
        int exp_pairs;
        int last;
        cfg_id++;
        cfg_fmt = f;
        cfg_n   = 16 + 4 * wl + ((wl == 3) ? 4 : 0);   // R9: codes 0..3 -> 16,20,24,32
        cfg_ofs = o;                                     // R10
        cfg_mask = ~(32'hFFFF_FFFF >> cfg_n);
        base = 2 * (o + cfg_n);
        case (variant)
            0: begin fl_w = base;     fl_a = base;     end // R8 single rate
            1: begin fl_w = base;     fl_a = 2 * base; end
            default: begin fl_w = 2 * base; fl_a = base + 2; end
        endcase
        @(negedge clk);
        rst = 1'b1;
        bclk = 1'b0;
        wclk = 1'b0;
        adwk = 1'b0;
        fmt_sel  = f[0];
        wlen_sel = 2'(wl);
        word_ofs = OW'(o);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rx_seen = 0;
        edges = 2 * ((fl_w > fl_a) ? fl_w : fl_a) + 2;
        for (int e = 0; e < edges; e++) step(e, 1'b0);
        repeat (4) @(negedge clk);
        exp_pairs = 0;
        for (int fr = 0; fr < edges; fr++) begin
            last = (f == 0) ? fr * fl_w + o + 2 * cfg_n
                            : (2 * fr + 1) * (fl_w / 2) + o + cfg_n;
            if (last <= edges - 1) exp_pairs++;
        end
        checks++;
        if (rx_seen != exp_pairs) begin
            errors++;
            $display("FAIL R5 cfg %0d pair count: got %0d expected %0d", cfg_id, rx_seen, exp_pairs);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (dout !== 1'b0 || rx_valid !== 1'b0 || rx_left !== '0 || rx_right !== '0) begin
            errors++;
            $display("FAIL R1 reset: dout %b valid %b left %h right %h expected 0 0 0 0",
                     dout, rx_valid, rx_left, rx_right);
        end
        tx_left  = 32'hFFFF_FFFF;
        tx_right = 32'hFFFF_FFFF;
        rst = 1'b0;
        // R11: no marker yet, so dout stays low and no pair is reported
        for (int e = 0; e < 6; e++) step(e, 1'b1);
        checks++;
        if (rx_seen != 0) begin
            errors++;
            $display("FAIL R11 idle strobes: got %0d expected 0", rx_seen);
        end
        for (int f = 0; f < 2; f++)
            for (int wl = 0; wl < 4; wl++)
                for (int oi = 0; oi < 2; oi++)
                    for (int v = 0; v < 3; v++)
                        run_cfg(f, wl, oi * 7, v);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule